// File: doc/BRIEF.md
# UART Transmit Character Queue with Word-Wide Loads

This block sits between a bus-facing transmit holding register and a UART serializer. Software or a DMA engine writes characters into the holding register in one of two widths. A narrow write loads one character. A wide write loads four characters packed into a 32-bit word. The queued characters leave through a valid/ready stream, one character per accepted transfer. A DMA request line tells the DMA engine when there is room for the next transfer. The amount of room it waits for is set by a programmable transmit-ready mode, so a DMA engine doing word writes is only called when a whole word fits.

A small mode register holds three things: a queue-enable bit, a transmit-ready mode and a receive-ready mode. The receive-ready mode is only stored and read back. With the queue disabled, the block acts as a classic one-character holding register. In that state both mode fields are held at zero, whatever value is written to them.

The serializer stream follows these back-pressure rules:
- `ser_valid` is high whenever at least one character is queued.
- `ser_data` shows the oldest character and does not change while `ser_valid` is high and `ser_ready` is low.
- A character is consumed in every cycle where both `ser_valid` and `ser_ready` are high.

The write side has no back-pressure. Bytes that do not fit are discarded and recorded in a sticky flag.

Top module: `uart_tx_fifo`

## Requirements
- R1: After reset the queue is empty (`ser_valid`=0), the queue is disabled, both mode readbacks are 0, `ovf_flag` is 0, and `tx_ready` and `dma_req` are 1.
- R2: A write with `thr_word`=0 queues `thr_data[7:0]`. A write with `thr_word`=1 queues four characters in the order bits 7:0, 15:8, 23:16, 31:24.
- R3: Characters leave in the order they were queued, one per cycle in which `ser_valid` and `ser_ready` are both high. While `ser_valid` is high and `ser_ready` is low, `ser_data` holds its value.
- R4: Capacity is DEPTH (16) characters when enabled and 1 character when disabled. Free space for a write is measured before any pop in the same cycle. When a write carries more characters than there is free space, only the lowest-order characters that fit are kept, the rest are dropped, and `ovf_flag` sets and stays set.
- R5: `tx_ready` is 1 when at least one slot is free. `dma_req` is 1 when the free slots reach the amount set by the transmit-ready mode: 2'b00 needs 1 slot, 2'b01 needs 2, and 2'b10 or 2'b11 need 4.
- R6: A mode write with `cfg_fifo_en`=1 stores the transmit-ready and receive-ready modes independently. The readbacks show exactly the values written.
- R7: A mode write with `cfg_fifo_en`=0 forces both mode readbacks to 0, whatever values are on `cfg_tx_mode` and `cfg_rx_mode`.
- R8: A `fifo_clr` pulse empties the queue and clears `ovf_flag` by the next cycle. Any write or pop in that same cycle is discarded.
- R9: A mode write that changes the enable state empties the queue and clears `ovf_flag`, just as `fifo_clr` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_fifo_en | input | 1 | Queue enable value to write |
| cfg_tx_mode | input | 2 | Transmit-ready mode value to write |
| cfg_rx_mode | input | 2 | Receive-ready mode value to write |
| fifo_clr | input | 1 | Empties the queue and clears the overflow flag |
| thr_we | input | 1 | Holding register write strobe |
| thr_word | input | 1 | 1 = four-character word write, 0 = single character |
| thr_data | input | 32 | Write data, character 0 in bits 7:0 |
| ser_valid | output | 1 | Character available to the serializer |
| ser_ready | input | 1 | Serializer accepts the character |
| ser_data | output | 8 | Oldest queued character |
| tx_ready | output | 1 | At least one free slot |
| dma_req | output | 1 | Free space meets the transmit-ready mode |
| ovf_flag | output | 1 | Sticky flag: bytes were dropped |
| fifo_en_q | output | 1 | Queue enable readback |
| tx_mode_q | output | 2 | Transmit-ready mode readback |
| rx_mode_q | output | 2 | Receive-ready mode readback |

## Verification
A wrong character count shows up at the ports within the same cycle, because `dma_req` and `tx_ready` are computed directly from the free space. A count that has drifted also makes `ser_valid` fall too early or too late during a drain. A bad read or write pointer shows up as a wrong `ser_data` at the very next pop, or as characters of a word arriving out of order. Mode-register faults show up immediately on the readbacks and on the `dma_req` threshold. The bench compares every output against a queue-based model on every cycle, so any of these faults is reported in the cycle where it first appears.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;

  typedef enum logic [1:0] {
    RDY_ONE   = 2'b00,
    RDY_TWO   = 2'b01,
    RDY_FOUR  = 2'b10,
    RDY_FOURX = 2'b11
  } rdy_mode_e;

  // Free slots required before a ready line asserts.
  function automatic int unsigned rdy_need(input logic [1:0] mode, input int unsigned lanes);
    case (mode)
      RDY_ONE: return 1;
      RDY_TWO: return 2;
      default: return lanes;
    endcase
  endfunction

endpackage

// File: rtl/txq_mode_reg.sv
module txq_mode_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_fifo_en,
  input  logic [1:0] cfg_tx_mode,
  input  logic [1:0] cfg_rx_mode,
  output logic       fifo_en_q,
  output logic [1:0] tx_mode_q,
  output logic [1:0] rx_mode_q,
  output logic       flush
);

  // Enable change empties the queue on the same edge.
  assign flush = cfg_we && (cfg_fifo_en != fifo_en_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifo_en_q <= 1'b0;
      tx_mode_q <= 2'b00;
      rx_mode_q <= 2'b00;
    end else if (cfg_we) begin
      fifo_en_q <= cfg_fifo_en;
      tx_mode_q <= cfg_fifo_en ? cfg_tx_mode : 2'b00;
      rx_mode_q <= cfg_fifo_en ? cfg_rx_mode : 2'b00;
    end
  end

  a_r7_legacy_modes_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en_q |-> (tx_mode_q == 2'b00 && rx_mode_q == 2'b00));

  a_r6_rx_holds_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(rx_mode_q) && $stable(tx_mode_q));

endmodule

// File: rtl/txq_ring.sv
module txq_ring #(
  parameter int DEPTH  = 16,
  parameter int CHAR_W = 8,
  parameter int LANES  = 4,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic [CNT_W-1:0]          cap,
  input  logic                      push_en,
  input  logic                      push_word,
  input  logic [CHAR_W*LANES-1:0]   push_data,
  input  logic                      pop,
  output logic [CNT_W-1:0]          count,
  output logic [CHAR_W-1:0]         head,
  output logic                      lost
);

  localparam int PTR_W = $clog2(DEPTH);

  logic [CHAR_W-1:0] mem [DEPTH];
  logic [CHAR_W-1:0] lane_char [LANES];
  logic [PTR_W-1:0]  wptr, rptr;
  logic [CNT_W-1:0]  n_req, free, n_acc;
  logic              do_pop;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_char[l] = push_data[l*CHAR_W +: CHAR_W];
  end

  assign n_req  = push_word ? CNT_W'(LANES) : CNT_W'(1);
  assign free   = cap - count;
  assign n_acc  = !push_en ? '0 : ((n_req > free) ? free : n_req);
  assign do_pop = pop && (count != '0);
  assign head   = mem[rptr];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      lost  <= 1'b0;
    end else begin
      if (do_pop) rptr <= rptr + 1'b1;
      wptr  <= wptr + PTR_W'(n_acc);
      count <= count + n_acc - CNT_W'(do_pop);
      if (push_en && (n_req > free)) lost <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (rst_n && !clear && (CNT_W'(l) < n_acc))
        mem[wptr + PTR_W'(l)] <= lane_char[l];
    end
  end

  a_r4_count_within_cap: assert property (@(posedge clk) disable iff (!rst_n)
    count <= cap);

  a_r4_lost_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lost && !clear |=> lost);

  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0) && !lost);

  a_r2_word_adds_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    push_en && push_word && !clear && !pop && (free >= CNT_W'(LANES))
    |=> count == $past(count) + CNT_W'(LANES));

endmodule

// File: rtl/txq_req.sv
module txq_req
  import uart_txq_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] cap,
  input  logic [1:0]       tx_mode,
  output logic             tx_ready,
  output logic             dma_req
);

  logic [CNT_W-1:0] free;
  logic [CNT_W-1:0] need;

  assign free     = cap - count;
  assign need     = CNT_W'(rdy_need(tx_mode, LANES));
  assign tx_ready = (free != '0);
  assign dma_req  = (free >= need);

  a_r5_four_mode_room: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && tx_mode[1] |-> (cap - count) >= CNT_W'(LANES));

endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DEPTH  = 16,
  parameter int CHAR_W = 8,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic                    cfg_fifo_en,
  input  logic [1:0]              cfg_tx_mode,
  input  logic [1:0]              cfg_rx_mode,
  input  logic                    fifo_clr,
  input  logic                    thr_we,
  input  logic                    thr_word,
  input  logic [CHAR_W*LANES-1:0] thr_data,
  output logic                    ser_valid,
  input  logic                    ser_ready,
  output logic [CHAR_W-1:0]       ser_data,
  output logic                    tx_ready,
  output logic                    dma_req,
  output logic                    ovf_flag,
  output logic                    fifo_en_q,
  output logic [1:0]              tx_mode_q,
  output logic [1:0]              rx_mode_q
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             flush, clear_any;
  logic [CNT_W-1:0] cap, count;

  txq_mode_reg u_mode (
    .clk, .rst_n, .cfg_we, .cfg_fifo_en, .cfg_tx_mode, .cfg_rx_mode,
    .fifo_en_q, .tx_mode_q, .rx_mode_q, .flush
  );

  assign clear_any = fifo_clr || flush;
  assign cap       = fifo_en_q ? CNT_W'(DEPTH) : CNT_W'(1);

  txq_ring #(.DEPTH(DEPTH), .CHAR_W(CHAR_W), .LANES(LANES), .CNT_W(CNT_W)) u_ring (
    .clk, .rst_n,
    .clear     (clear_any),
    .cap       (cap),
    .push_en   (thr_we),
    .push_word (thr_word),
    .push_data (thr_data),
    .pop       (ser_ready),
    .count     (count),
    .head      (ser_data),
    .lost      (ovf_flag)
  );

  assign ser_valid = (count != '0);

  txq_req #(.LANES(LANES), .CNT_W(CNT_W)) u_req (
    .clk, .rst_n, .count, .cap,
    .tx_mode (tx_mode_q),
    .tx_ready,
    .dma_req
  );

  a_r3_head_held: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid && !ser_ready && !clear_any |=> ser_valid && $stable(ser_data));

  a_r9_enable_change_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !ser_valid);

endmodule

// File: tb/tb_uart_tx_fifo.sv
`timescale 1ns/100ps
module tb_uart_tx_fifo;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 0, cfg_fifo_en = 0, fifo_clr = 0, thr_we = 0, thr_word = 0, ser_ready = 0;
  logic [1:0]  cfg_tx_mode = 0, cfg_rx_mode = 0;
  logic [31:0] thr_data = 0;
  logic        ser_valid, tx_ready, dma_req, ovf_flag, fifo_en_q;
  logic [7:0]  ser_data;
  logic [1:0]  tx_mode_q, rx_mode_q;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  byte unsigned q[$];
  bit       m_en = 0, m_ovf = 0;
  bit [1:0] m_tx = 0, m_rx = 0;

  always #2.5 clk = ~clk;

  uart_tx_fifo dut (
    .clk, .rst_n, .cfg_we, .cfg_fifo_en, .cfg_tx_mode, .cfg_rx_mode, .fifo_clr,
    .thr_we, .thr_word, .thr_data, .ser_valid, .ser_ready, .ser_data,
    .tx_ready, .dma_req, .ovf_flag, .fifo_en_q, .tx_mode_q, .rx_mode_q
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit flush;
    flush = cfg_we && (cfg_fifo_en != m_en);
    if (fifo_clr || flush) begin
      q.delete();
      m_ovf = 0;
    end else begin
      int cap, free, n, acc;
      bit pop;
      cap  = m_en ? 16 : 1;
      free = cap - q.size();
      n    = thr_word ? 4 : 1;
      pop  = ser_ready && (q.size() > 0);
      if (pop) void'(q.pop_front());
      if (thr_we) begin
        acc = (n > free) ? free : n;
        if (n > free) m_ovf = 1;
        for (int i = 0; i < acc; i++) q.push_back(thr_data[i*8 +: 8]);
      end
    end
    if (cfg_we) begin
      m_en = cfg_fifo_en;
      m_tx = cfg_fifo_en ? cfg_tx_mode : 2'b00;
      m_rx = cfg_fifo_en ? cfg_rx_mode : 2'b00;
    end
  endtask

  task automatic compare_all();
    int cap, free, need;
    cap  = m_en ? 16 : 1;
    free = cap - q.size();
    need = (m_tx == 2'b00) ? 1 : (m_tx == 2'b01) ? 2 : 4;
    chk("R3 ser_valid", ser_valid, q.size() > 0);
    if (q.size() > 0) chk("R3 ser_data order", ser_data, q[0]);
    chk("R5 tx_ready", tx_ready, free >= 1);
    chk("R5 dma_req threshold", dma_req, free >= need);
    chk("R4 ovf_flag", ovf_flag, m_ovf);
    chk("R6 fifo_en_q", fifo_en_q, m_en);
    chk("R6 tx_mode_q", tx_mode_q, m_tx);
    chk("R6 rx_mode_q", rx_mode_q, m_rx);
  endtask

  task automatic idle();
    cfg_we = 0; fifo_clr = 0; thr_we = 0; thr_word = 0;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    idle();
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ser_valid", ser_valid, 0);
    chk("R1 fifo_en_q", fifo_en_q, 0);
    chk("R1 tx_mode_q", tx_mode_q, 0);
    chk("R1 rx_mode_q", rx_mode_q, 0);
    chk("R1 ovf_flag", ovf_flag, 0);
    chk("R1 tx_ready", tx_ready, 1);
    chk("R1 dma_req", dma_req, 1);

    // legacy single holding register
    thr_we = 1; thr_data = 32'h0000_00A5; cyc();
    chk("R2 legacy byte", ser_data, 8'hA5);
    thr_we = 1; thr_data = 32'h0000_005A; cyc();
    chk("R4 legacy capacity keeps head", ser_data, 8'hA5);
    chk("R4 legacy overflow", ovf_flag, 1);
    chk("R4 legacy full", tx_ready, 0);
    fifo_clr = 1; ser_ready = 1; thr_we = 1; thr_data = 32'h77; cyc();
    ser_ready = 0;
    chk("R8 clear empties", ser_valid, 0);
    chk("R8 clear ovf", ovf_flag, 0);
    cfg_we = 1; cfg_fifo_en = 0; cfg_tx_mode = 2'b10; cfg_rx_mode = 2'b01; cyc();
    chk("R7 tx mode forced 0", tx_mode_q, 0);
    chk("R7 rx mode forced 0", rx_mode_q, 0);

    // enable, four-character transmit readiness, single-character receive
    cfg_we = 1; cfg_fifo_en = 1; cfg_tx_mode = 2'b10; cfg_rx_mode = 2'b00; cyc();
    chk("R6 tx mode four", tx_mode_q, 2'b10);
    chk("R6 rx mode one", rx_mode_q, 2'b00);
    thr_we = 1; thr_word = 1; thr_data = 32'h4433_2211; cyc();
    chk("R2 word lsb first", ser_data, 8'h11);
    for (int w = 0; w < 2; w++) begin
      thr_we = 1; thr_word = 1; thr_data = 32'hA0B0C0D0 + w; cyc();
    end
    chk("R5 four free gives req", dma_req, 1);
    thr_we = 1; thr_data = 32'hEE; cyc();
    chk("R5 three free drops req", dma_req, 0);
    chk("R5 tx_ready with room", tx_ready, 1);
    cfg_we = 1; cfg_fifo_en = 1; cfg_tx_mode = 2'b00; cfg_rx_mode = 2'b00; cyc();
    chk("R5 one mode req", dma_req, 1);
    chk("R9 no flush without change", ser_data, 8'h11);
    thr_we = 1; thr_word = 1; thr_data = 32'h9988_7766; cyc();
    chk("R4 word overflow flag", ovf_flag, 1);
    chk("R4 full after partial", tx_ready, 0);

    ser_ready = 1;
    cyc(); chk("R3 second char", ser_data, 8'h22);
    cyc(); chk("R3 third char", ser_data, 8'h33);
    cyc(); chk("R3 fourth char", ser_data, 8'h44);
    for (int i = 0; i < 13; i++) cyc();
    chk("R4 drained exactly 16", ser_valid, 0);
    ser_ready = 0;

    thr_we = 1; thr_data = 32'h3C; cyc();
    cfg_we = 1; cfg_fifo_en = 0; cyc();
    chk("R9 enable change flushes", ser_valid, 0);
    chk("R9 flush clears ovf", ovf_flag, 0);

    // randomised traffic against the model
    for (int i = 0; i < 4000; i++) begin
      fifo_clr    = ($urandom_range(0, 99) == 0);
      cfg_we      = ($urandom_range(0, 79) == 0);
      cfg_fifo_en = ($urandom_range(0, 7) != 0);
      cfg_tx_mode = 2'($urandom_range(0, 3));
      cfg_rx_mode = 2'($urandom_range(0, 3));
      thr_we      = ($urandom_range(0, 2) != 0);
      thr_word    = $urandom_range(0, 1);
      thr_data    = $urandom;
      ser_ready   = ($urandom_range(0, 3) < ((i / 500) % 4));
      cyc();
    end

    done = 1;
    summary();
    $finish;
  end

endmodule